// File: doc/BRIEF.md
# Indexed Port Register Access Window

This block gives software a small I/O window through which it reaches the per-port link registers of a four-port serial link controller. Each port has three such registers: status, control and error. Mapping all twelve into the address space would take more room than the legacy I/O map allows. Instead, software first writes a selector word into an index register. That word names a port and one of its three registers. Software then reads or writes the data register, and the block steers the access to the chosen target.

The window is four words deep and sits on a simple register bus. The bus has a 4-bit byte address, separate read and write strobes, and 32-bit data. An enable input says whether the controller runs in its legacy programming mode. While it is low, the window claims nothing and changes nothing.

The block holds the control and error registers of every port. The status words come in from the link logic, which also raises error events. The port field of the index is not linear: codes 1 and 2 are swapped. Selector codes that name no target, and the two spare words of the window, absorb accesses silently.

Top module: `link_idx_window`

## Requirements
- R1: The index register (bus_addr[3:2] = 0) resets to 0. Bits 15:0 are stored on a write, and a read returns them with bits 31:16 forced to zero.
- R2: Index bits 15:8 are the port code. Code 0 selects port 0, code 1 selects port 2, code 2 selects port 1 and code 3 selects port 3. Each port's registers are separate, so an access to one port never changes another port.
- R3: Index bits 7:0 are the register code. Code 0 selects link status, code 1 selects link control and code 2 selects link error. The data register sits at bus_addr[3:2] = 1.
- R4: A port code above 3 or a register code above 2 makes a data-register read return zero, and a data-register write changes no register.
- R5: The words at bus_addr[3:2] = 2 and 3 read as zero, and writes to them change no register.
- R6: Link status is read-only through the window. A read returns the live lnk_sts word of the selected port, and a write to it is dropped.
- R7: Link control resets to zero and is fully read/write. A write through the data register replaces the whole word, which appears on lnk_ctl after the write edge.
- R8: Link error resets to zero. Each bit is set by a lnk_err_set pulse and cleared by writing a one to it through the data register. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: Read data appears on bus_rdata with bus_rvalid high in the cycle after the read strobe is sampled. bus_rvalid is high for exactly one cycle per read cycle.
- R10: While legacy_en is low, bus_claim stays low, no read returns bus_rvalid, and writes change no register. While legacy_en is high, bus_claim is high whenever a strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Window enabled (legacy programming mode) |
| bus_addr | input | 4 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_claim | output | 1 | Access is claimed by the window |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| lnk_sts | input | NPORTS*32 | Status word of each port, port p at bits [p*32 +: 32] |
| lnk_err_set | input | NPORTS*32 | Error event pulses per port and bit |
| lnk_ctl | output | NPORTS*32 | Control register of each port |
| lnk_err | output | NPORTS*32 | Error register of each port |

## Verification
A wrong index decode shows up on the first data read after the index is written. The read arrives one cycle later and carries the word of the wrong port or register, or zero. A write steered to the wrong target stays hidden until that target is read back. For that reason every target is read again after the sweep, and any stray change to another port shows up there. A fault in error clearing or in set priority appears on lnk_err one cycle after the write edge. The same fault appears on the next window read of that register.

// File: rtl/link_idx_pkg.sv
package link_idx_pkg;
  localparam int LW_NPORTS = 4;
  localparam int PORT_W    = $clog2(LW_NPORTS);
  localparam int CODE_W    = 8;
  localparam int IDX_W     = 2 * CODE_W;

  typedef enum logic [1:0] {
    TGT_STS  = 2'd0,
    TGT_CTL  = 2'd1,
    TGT_ERR  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef struct packed {
    logic              ok;
    logic [PORT_W-1:0] port;
  } port_sel_t;

  // Port code to physical port: codes 1 and 2 are crossed over.
  function automatic port_sel_t map_port(input logic [CODE_W-1:0] code);
    port_sel_t s;
    s.ok = (code < CODE_W'(LW_NPORTS));
    if (code == CODE_W'(1))      s.port = PORT_W'(2);
    else if (code == CODE_W'(2)) s.port = PORT_W'(1);
    else                         s.port = code[PORT_W-1:0];
    return s;
  endfunction

  function automatic tgt_e map_reg(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(0): return TGT_STS;
      CODE_W'(1): return TGT_CTL;
      CODE_W'(2): return TGT_ERR;
      default:    return TGT_NONE;
    endcase
  endfunction

  // Write-one-to-clear with new events taking precedence.
  function automatic logic [31:0] w1c_merge(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/lw_index_reg.sv
module lw_index_reg
  import link_idx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              sel_ok,
  output logic [PORT_W-1:0] sel_port,
  output tgt_e              sel_reg
);
  port_sel_t ps;

  always_ff @(posedge clk) begin
    if (!rst_n)  idx_q <= '0;
    else if (we) idx_q <= wdata;
  end

  always_comb begin
    ps       = map_port(idx_q[IDX_W-1:CODE_W]);
    sel_reg  = map_reg(idx_q[CODE_W-1:0]);
    sel_port = ps.port;
    sel_ok   = ps.ok && (sel_reg != TGT_NONE);
  end

  // R1: index changes only on an index write
  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(idx_q));
  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (idx_q == $past(wdata)));
endmodule

// File: rtl/lw_port_regs.sv
module lw_port_regs
  import link_idx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic         err_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] err_set,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] err_q
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] err_nxt;

  assign clr_mask = err_we ? wdata : '0;
  assign err_nxt  = w1c_merge(err_q, clr_mask, err_set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= '0;
    end else begin
      if (ctl_we) ctl_q <= wdata;
      err_q <= err_nxt;
    end
  end

  // R7: control loads only on its own write
  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));
  p_ctl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q == $past(wdata)));
  // R8: events always land; bits only fall on a clear write
  p_err_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_we |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
  import link_idx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [1:0]       off,
  input  logic [IDX_W-1:0] idx_q,
  input  logic [W-1:0]     tgt_word,
  output logic [W-1:0]     rdata,
  output logic             rvalid
);
  logic [W-1:0] rd_nxt;

  always_comb begin
    case (off)
      2'd0:    rd_nxt = {{(W-IDX_W){1'b0}}, idx_q};
      2'd1:    rd_nxt = tgt_word;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_nxt;
    end
  end

  // R9: one valid cycle per sampled read
  p_rvalid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_rvalid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R5: spare words read zero
  p_rsvd_off_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off[1]) |=> (rdata == '0));
  // R1: upper index bits read zero
  p_idx_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && off == 2'd0) |=> (rdata[W-1:IDX_W] == '0));
endmodule

// File: rtl/link_idx_window.sv
module link_idx_window
  import link_idx_pkg::*;
#(
  parameter int NPORTS = LW_NPORTS,
  parameter int W      = 32,
  parameter int AW     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               legacy_en,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [W-1:0]       bus_wdata,
  output logic               bus_claim,
  output logic [W-1:0]       bus_rdata,
  output logic               bus_rvalid,
  input  logic [NPORTS*W-1:0] lnk_sts,
  input  logic [NPORTS*W-1:0] lnk_err_set,
  output logic [NPORTS*W-1:0] lnk_ctl,
  output logic [NPORTS*W-1:0] lnk_err
);
  localparam logic [1:0] OFF_IDX  = 2'd0;
  localparam logic [1:0] OFF_DATA = 2'd1;

  logic [1:0]        off;
  logic              rd_en, wr_en;
  logic              idx_we, data_we;
  logic [IDX_W-1:0]  idx_q;
  logic              sel_ok;
  logic [PORT_W-1:0] sel_port;
  tgt_e              sel_reg;
  logic [W-1:0]      tgt_word;
  logic [NPORTS-1:0] ctl_we, err_we;
  logic              unused_bits;

  assign off       = bus_addr[AW-1:AW-2];
  assign rd_en     = legacy_en && bus_rd;
  assign wr_en     = legacy_en && bus_wr;
  assign bus_claim = legacy_en && (bus_rd || bus_wr);
  assign idx_we    = wr_en && (off == OFF_IDX);
  assign data_we   = wr_en && (off == OFF_DATA);
  assign unused_bits = ^{bus_addr[AW-3:0], bus_wdata[W-1:IDX_W]};

  lw_index_reg u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (idx_we),
    .wdata    (bus_wdata[IDX_W-1:0]),
    .idx_q    (idx_q),
    .sel_ok   (sel_ok),
    .sel_port (sel_port),
    .sel_reg  (sel_reg)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit       = data_we && sel_ok && (sel_port == PORT_W'(p));
    assign ctl_we[p] = hit && (sel_reg == TGT_CTL);
    assign err_we[p] = hit && (sel_reg == TGT_ERR);

    lw_port_regs #(.W(W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (ctl_we[p]),
      .err_we  (err_we[p]),
      .wdata   (bus_wdata),
      .err_set (lnk_err_set[p*W +: W]),
      .ctl_q   (lnk_ctl[p*W +: W]),
      .err_q   (lnk_err[p*W +: W])
    );
  end

  always_comb begin
    tgt_word = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (sel_ok && sel_port == PORT_W'(p)) begin
        case (sel_reg)
          TGT_STS: tgt_word = lnk_sts[p*W +: W];
          TGT_CTL: tgt_word = lnk_ctl[p*W +: W];
          TGT_ERR: tgt_word = lnk_err[p*W +: W];
          default: tgt_word = '0;
        endcase
      end
    end
  end

  lw_read_path #(.W(W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .off      (off),
    .idx_q    (idx_q),
    .tgt_word (tgt_word),
    .rdata    (bus_rdata),
    .rvalid   (bus_rvalid)
  );

  // R10: a disabled window returns nothing
  p_unclaimed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_en |=> !bus_rvalid);
  // R4: reserved selector codes write nothing
  p_rsvd_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !sel_ok) |=> $stable(lnk_ctl));
  // R5: spare words write nothing
  p_rsvd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off[1]) |=> ($stable(idx_q) && $stable(lnk_ctl)));
  // R2: at most one port's registers are written per cycle
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_we | err_we));
endmodule

// File: tb/link_idx_window_tb.sv
`timescale 1ns/1ps
module link_idx_window_tb;
  localparam int NP = 4;
  localparam int W  = 32;

  logic clk = 1'b0, rst_n = 1'b0, legacy_en = 1'b1;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_claim, bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NP*W-1:0] lnk_sts, lnk_err_set, lnk_ctl, lnk_err;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ctl_m[NP], err_m[NP], sts_m[NP];
  logic [15:0] idx_m;

  always #4 clk = ~clk;

  link_idx_window u_dut (
    .clk(clk), .rst_n(rst_n), .legacy_en(legacy_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_claim(bus_claim), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lnk_sts(lnk_sts), .lnk_err_set(lnk_err_set),
    .lnk_ctl(lnk_ctl), .lnk_err(lnk_err)
  );

  function automatic int exp_port(input int code);
    case (code)
      0: return 0;
      1: return 2;
      2: return 1;
      3: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_data();
    int p, rc;
    p  = exp_port(int'(idx_m[15:8]));
    rc = int'(idx_m[7:0]);
    if (p < 0 || rc > 2) return 32'h0;
    if (rc == 0) return sts_m[p];
    if (rc == 1) return ctl_m[p];
    return err_m[p];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check({req, " rvalid"}, {31'b0, bus_rvalid}, 32'h1);
    check(req, bus_rdata, exp);
  endtask

  task automatic set_idx(input int pc, input int rc);
    do_write(4'h0, {16'hBEEF, 8'(pc), 8'(rc)});
    idx_m = {8'(pc), 8'(rc)};
  endtask

  task automatic pulse_err(input int p, input logic [31:0] m);
    @(negedge clk);
    lnk_err_set[p*W +: W] = m;
    @(negedge clk);
    lnk_err_set = '0;
    err_m[p] = err_m[p] | m;
  endtask

  task automatic readback_all(input string req);
    for (int pc = 0; pc < NP; pc++)
      for (int rc = 0; rc < 3; rc++) begin
        set_idx(pc, rc);
        rd_chk(req, 4'h4, exp_data());
      end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int pcs[6] = '{0, 1, 2, 3, 4, 255};
    int rcs[5] = '{0, 1, 2, 3, 255};
    logic [31:0] pat;
    int p;
    string tag;

    lnk_err_set = '0;
    for (int i = 0; i < NP; i++) begin
      sts_m[i] = 32'h5A00_00C3 ^ (32'(i) << 12) ^ 32'(i);
      lnk_sts[i*W +: W] = sts_m[i];
      ctl_m[i] = '0;
      err_m[i] = '0;
    end
    idx_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R9 idle rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    rd_chk("R1 index reset", 4'h0, 32'h0);
    readback_all("R2 R3 reset readback");

    for (int i = 0; i < NP; i++)
      pulse_err(i, 32'hF0F0_0F0F ^ (32'(i) << 4));
    for (int i = 0; i < NP; i++)
      check("R8 event sets lnk_err", lnk_err[i*W +: W], err_m[i]);

    do_write(4'h0, 32'hFFFF_0102);
    idx_m = 16'h0102;
    rd_chk("R1 index upper bits zero", 4'h0, 32'h0000_0102);

    foreach (pcs[a]) foreach (rcs[b]) begin
      set_idx(pcs[a], rcs[b]);
      pat = 32'h1357_9BDF ^ {8'(pcs[a]), 8'(rcs[b]), 8'(pcs[a]), 8'(rcs[b])};
      do_write(4'h4, pat);
      p = exp_port(pcs[a]);
      if (p >= 0 && rcs[b] == 1) ctl_m[p] = pat;
      if (p >= 0 && rcs[b] == 2) err_m[p] = err_m[p] & ~pat;
      if (p < 0 || rcs[b] > 2) tag = "R4 reserved code";
      else if (rcs[b] == 0)    tag = "R6 status read-only";
      else if (rcs[b] == 1)    tag = "R7 control write";
      else                     tag = "R8 error clear";
      rd_chk(tag, 4'h4, exp_data());
      if (p >= 0 && rcs[b] == 1) check("R7 lnk_ctl output", lnk_ctl[p*W +: W], pat);
    end

    set_idx(2, 1);
    do_write(4'h8, 32'hFFFF_FFFF);
    do_write(4'hC, 32'hFFFF_FFFF);
    rd_chk("R5 spare word 8", 4'h8, 32'h0);
    rd_chk("R5 spare word C", 4'hC, 32'h0);
    rd_chk("R5 index untouched", 4'h0, {16'h0, idx_m});
    rd_chk("R5 target untouched", 4'h4, exp_data());

    set_idx(1, 2);
    pulse_err(2, 32'h0000_0008);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_000C;
    lnk_err_set[2*W +: W] = 32'h0000_0008;
    @(negedge clk);
    bus_wr = 1'b0; lnk_err_set = '0;
    err_m[2] = (err_m[2] & ~32'h0000_000C) | 32'h0000_0008;
    rd_chk("R8 set beats clear", 4'h4, err_m[2]);
    check("R8 bit 3 kept", {31'b0, lnk_err[2*W + 3]}, 32'h1);

    legacy_en = 1'b0;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'h0;
    #1 check("R10 no claim when disabled", {31'b0, bus_claim}, 32'h0);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R10 no rvalid when disabled", {31'b0, bus_rvalid}, 32'h0);
    do_write(4'h0, 32'h0000_0300);
    do_write(4'h4, 32'hFFFF_FFFF);
    legacy_en = 1'b1;
    rd_chk("R10 index unchanged", 4'h0, {16'h0, idx_m});
    rd_chk("R10 error unchanged", 4'h4, err_m[2]);

    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'h0;
    #1 check("R10 claim when enabled", {31'b0, bus_claim}, 32'h1);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R9 rvalid one cycle later", {31'b0, bus_rvalid}, 32'h1);
    @(negedge clk);
    check("R9 rvalid drops", {31'b0, bus_rvalid}, 32'h0);

    readback_all("R2 no crosstalk");
    for (int i = 0; i < NP; i++)
      check("R7 final lnk_ctl", lnk_ctl[i*W +: W], ctl_m[i]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule